// File: doc/BRIEF.md
# Undersampling IQ Demodulator

This block recovers the in-phase (I) and quadrature (Q) parts of an RF carrier from a stream of signed samples taken directly, without a mixer. The sample rate is f0·N/M, far below the carrier f0. Successive samples therefore land on carrier phases that advance by 2π·M/N each, which is a fixed cycle of N phase points spread over M carrier periods. With the default N = 5, M = 24 (270.83 MHz for a 1.3 GHz carrier), the phase index of sample k is (4k) mod 5.

Each accepted sample is multiplied by a cosine weight and a sine weight that are chosen by its phase index. The two products are summed over a window of L samples, where L is a whole multiple of N. The sums are scaled by 2/L through a multiply with a precomputed fixed-point reciprocal. A window opens with a start pulse on a valid sample. When the window completes, the block emits one I/Q pair with a single-cycle strobe. Conversion to amplitude and phase happens downstream.

Top module: `iq_undersample_demod`

## Requirements
- R1: While and right after reset, out_valid is 0 and out_i and out_q are 0.
- R2: A valid sample with in_start high gets phase index 0. Each later sample of the window gets index (previous + PH_STEP) mod NUM_PH. The defaults are NUM_PH = 5 and PH_STEP = 4, so the order is 0,4,3,2,1.
- R3: Weights are Q1.14 signed. For phase p = 0..4, cos is 16384, 5063, -13255, -13255, 5063 and sin is 0, 15582, 9630, -9630, -15582.
- R4: out_i is floor(A_I·RC / 2^SCALE_SHIFT), truncated to OUT_W bits. A_I is the window sum of sample·cos weight, and RC = (2^(SCALE_SHIFT+1) + WIN_LEN/2) div WIN_LEN.
- R5: out_q is formed in the same way from the window sum of sample·sin weight.
- R6: out_valid is high for exactly one cycle. It rises after the second rising edge following the edge that accepts the WIN_LEN-th sample of the window.
- R7: Cycles with in_valid low do not affect the result, whatever in_sample and in_start carry. A window may contain gaps.
- R8: A valid sample with in_start high in the middle of a window drops the partial sums and starts a fresh window at phase 0.
- R9: Valid samples before the first start, or after a window has completed, are ignored until the next start, and they produce no output.
- R10: out_i and out_q keep their values between strobes.
- R11: A start on the sample directly after a window's last sample begins the next window with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample qualifier |
| in_start | input | 1 | Opens a new window on a valid sample |
| in_sample | input | SAMPLE_W | Signed two's-complement sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_i | output | OUT_W | Scaled in-phase result |
| out_q | output | OUT_W | Scaled quadrature result |

## Verification
The bench builds the block with WIN_LEN = 10 and the other parameters at their defaults. A window then spans only two turns of the five-point phase cycle. This short window makes it practical to sweep a single full-scale impulse, positive and negative, across every sample position, so each of the ten weights passes through the scaler in isolation. It also allows many windows with gaps, restarts, stray samples and pseudo-random data to be checked against an arithmetic model.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

   localparam int IQD_WEIGHT_W = 16;

   typedef struct packed {
      logic vld;
      logic first;
      logic last;
   } iqd_ctl_t;

   // five-point cycle, angle 72 degrees times p, Q1.14
   function automatic logic signed [IQD_WEIGHT_W-1:0] pent_cos(input logic [3:0] p);
      case (p)
         4'd0:    return 16'sd16384;
         4'd1:    return 16'sd5063;
         4'd2:    return -16'sd13255;
         4'd3:    return -16'sd13255;
         4'd4:    return 16'sd5063;
         default: return 16'sd0;
      endcase
   endfunction

   function automatic logic signed [IQD_WEIGHT_W-1:0] pent_sin(input logic [3:0] p);
      case (p)
         4'd1:    return 16'sd15582;
         4'd2:    return 16'sd9630;
         4'd3:    return -16'sd9630;
         4'd4:    return -16'sd15582;
         default: return 16'sd0;
      endcase
   endfunction

   // four-point cycle, quarter-wave steps
   function automatic logic signed [IQD_WEIGHT_W-1:0] quad_cos(input logic [3:0] p);
      case (p)
         4'd0:    return 16'sd16384;
         4'd2:    return -16'sd16384;
         default: return 16'sd0;
      endcase
   endfunction

   function automatic logic signed [IQD_WEIGHT_W-1:0] quad_sin(input logic [3:0] p);
      case (p)
         4'd1:    return 16'sd16384;
         4'd3:    return -16'sd16384;
         default: return 16'sd0;
      endcase
   endfunction

endpackage

// File: rtl/iqd_phase_seq.sv
module iqd_phase_seq #(
   parameter int NUM_PH  = 5,
   parameter int PH_STEP = 4,
   parameter int WIN_LEN = 1280,
   localparam int PH_W   = $clog2(NUM_PH),
   localparam int CNT_W  = $clog2(WIN_LEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_start,
   output logic            take_o,
   output logic            first_o,
   output logic            last_o,
   output logic [PH_W-1:0] phase_o
);

   logic            running_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PH_W-1:0] phase_q;
   logic [CNT_W-1:0] cur_cnt;
   logic [PH_W:0]   ph_sum;
   logic [PH_W-1:0] ph_next;

   always_comb begin
      take_o  = 1'b0;
      first_o = 1'b0;
      cur_cnt = cnt_q;
      phase_o = phase_q;
      if (in_valid && in_start) begin
         take_o  = 1'b1;
         first_o = 1'b1;
         cur_cnt = '0;
         phase_o = '0;
      end else if (in_valid && running_q) begin
         take_o = 1'b1;
      end
      last_o = take_o && (cur_cnt == CNT_W'(WIN_LEN - 1));
      ph_sum = {1'b0, phase_o} + (PH_W+1)'(PH_STEP);
      if (ph_sum >= (PH_W+1)'(NUM_PH))
         ph_next = PH_W'(ph_sum - (PH_W+1)'(NUM_PH));
      else
         ph_next = ph_sum[PH_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
         phase_q   <= '0;
      end else if (take_o) begin
         running_q <= !last_o;
         cnt_q     <= cur_cnt + CNT_W'(1);
         phase_q   <= ph_next;
      end
   end

endmodule

// File: rtl/iqd_weight_lut.sv
module iqd_weight_lut
   import iqd_pkg::*;
#(
   parameter int NUM_PH = 5,
   localparam int PH_W  = $clog2(NUM_PH)
) (
   input  logic [PH_W-1:0]                 phase_i,
   output logic signed [IQD_WEIGHT_W-1:0]  cos_o,
   output logic signed [IQD_WEIGHT_W-1:0]  sin_o
);

   generate
      if (NUM_PH == 5) begin : g_pent
         always_comb begin
            cos_o = pent_cos(4'(phase_i));
            sin_o = pent_sin(4'(phase_i));
         end
      end else begin : g_quad
         always_comb begin
            cos_o = quad_cos(4'(phase_i));
            sin_o = quad_sin(4'(phase_i));
         end
      end
   endgenerate

endmodule

// File: rtl/iqd_mac_lane.sv
module iqd_mac_lane #(
   parameter int SAMPLE_W    = 14,
   parameter int WEIGHT_W    = 16,
   parameter int ACC_W       = 48,
   parameter int OUT_W       = 30,
   parameter int WIN_LEN     = 1280,
   parameter int SCALE_SHIFT = 24,
   localparam int PRD_W      = SAMPLE_W + WEIGHT_W,
   localparam int RC_W       = SCALE_SHIFT + 2,
   localparam int SCL_W      = ACC_W + RC_W,
   localparam longint RC_VAL = ((64'sd1 <<< (SCALE_SHIFT + 1)) + 64'(WIN_LEN / 2)) / 64'(WIN_LEN)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_en,
   input  logic signed [SAMPLE_W-1:0] sample_i,
   input  logic signed [WEIGHT_W-1:0] weight_i,
   input  logic                       acc_en,
   input  logic                       acc_clr,
   input  logic                       load_en,
   output logic signed [OUT_W-1:0]    result_o
);

   localparam logic signed [RC_W-1:0] RC_C = RC_W'(RC_VAL);

   logic signed [PRD_W-1:0] prod_q;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [SCL_W-1:0] scl_full;
   logic signed [SCL_W-1:0] scl_shift;

   always_ff @(posedge clk) begin
      if (!rst_n)
         prod_q <= '0;
      else if (smp_en)
         prod_q <= PRD_W'(sample_i) * PRD_W'(weight_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else if (acc_en)
         acc_q <= acc_clr ? ACC_W'(prod_q) : acc_q + ACC_W'(prod_q);
   end

   always_comb begin
      scl_full  = SCL_W'(acc_q) * SCL_W'(RC_C);
      scl_shift = scl_full >>> SCALE_SHIFT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         result_o <= '0;
      else if (load_en)
         result_o <= scl_shift[OUT_W-1:0];
   end

endmodule

// File: rtl/iq_undersample_demod.sv
module iq_undersample_demod
   import iqd_pkg::*;
#(
   parameter int SAMPLE_W    = 14,
   parameter int NUM_PH      = 5,
   parameter int PH_STEP     = 4,
   parameter int WIN_LEN     = 1280,
   parameter int ACC_W       = 48,
   parameter int OUT_W       = 30,
   parameter int SCALE_SHIFT = 24,
   localparam int PH_W       = $clog2(NUM_PH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       in_start,
   input  logic signed [SAMPLE_W-1:0] in_sample,
   output logic                       out_valid,
   output logic signed [OUT_W-1:0]    out_i,
   output logic signed [OUT_W-1:0]    out_q
);

   generate
      if (NUM_PH != 4 && NUM_PH != 5) begin : g_bad_ph
         $error("NUM_PH must be 4 or 5");
      end
      if (PH_STEP < 1 || PH_STEP >= NUM_PH) begin : g_bad_step
         $error("PH_STEP must lie in 1..NUM_PH-1");
      end
      if (WIN_LEN % NUM_PH != 0 || WIN_LEN < 2 * NUM_PH) begin : g_bad_len
         $error("WIN_LEN must be a multiple of NUM_PH, at least two cycles");
      end
      if (ACC_W < SAMPLE_W + IQD_WEIGHT_W + $clog2(WIN_LEN)) begin : g_bad_acc
         $error("ACC_W too narrow for WIN_LEN products");
      end
      if (SCALE_SHIFT < 8 || SCALE_SHIFT > 40) begin : g_bad_shift
         $error("SCALE_SHIFT out of range");
      end
   endgenerate

   logic            take, first, last;
   logic [PH_W-1:0] phase;
   logic signed [IQD_WEIGHT_W-1:0] w_cos, w_sin;
   iqd_ctl_t        ctl_s1;
   logic            done_s2;
   logic            valid_q;
   logic signed [OUT_W-1:0] lane_res [2];

   iqd_phase_seq #(
      .NUM_PH (NUM_PH),
      .PH_STEP(PH_STEP),
      .WIN_LEN(WIN_LEN)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(in_valid),
      .in_start(in_start),
      .take_o  (take),
      .first_o (first),
      .last_o  (last),
      .phase_o (phase)
   );

   iqd_weight_lut #(
      .NUM_PH(NUM_PH)
   ) i_lut (
      .phase_i(phase),
      .cos_o  (w_cos),
      .sin_o  (w_sin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_s1  <= '0;
         done_s2 <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         ctl_s1  <= '{vld: take, first: first, last: last};
         done_s2 <= ctl_s1.vld && ctl_s1.last;
         valid_q <= done_s2;
      end
   end

   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         iqd_mac_lane #(
            .SAMPLE_W   (SAMPLE_W),
            .WEIGHT_W   (IQD_WEIGHT_W),
            .ACC_W      (ACC_W),
            .OUT_W      (OUT_W),
            .WIN_LEN    (WIN_LEN),
            .SCALE_SHIFT(SCALE_SHIFT)
         ) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_en  (take),
            .sample_i(in_sample),
            .weight_i((g == 0) ? w_cos : w_sin),
            .acc_en  (ctl_s1.vld),
            .acc_clr (ctl_s1.first),
            .load_en (done_s2),
            .result_o(lane_res[g])
         );
      end
   endgenerate

   assign out_valid = valid_q;
   assign out_i     = lane_res[0];
   assign out_q     = lane_res[1];

endmodule

// File: rtl/iqd_checker.sv
module iqd_checker #(
   parameter int OUT_W = 30
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_start,
   input logic                    out_valid,
   input logic signed [OUT_W-1:0] out_i,
   input logic signed [OUT_W-1:0] out_q
);

   logic seen_start_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         seen_start_q <= 1'b0;
      else if (in_valid && in_start)
         seen_start_q <= 1'b1;
   end

   // R6
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R6
   strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 3));

   // R9
   start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> seen_start_q);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_i) && $stable(out_q)));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

endmodule

bind iq_undersample_demod iqd_checker #(.OUT_W(OUT_W)) i_iqd_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_start (in_start),
   .out_valid(out_valid),
   .out_i    (out_i),
   .out_q    (out_q)
);

// File: tb/test_iq_undersample_demod.sv
module test_iq_undersample_demod;

   localparam int SW = 14;
   localparam int OW = 30;
   localparam int L  = 10;
   localparam int SH = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_start = 1'b0;
   logic signed [SW-1:0] in_sample = '0;
   logic out_valid;
   logic signed [OW-1:0] out_i, out_q;

   always #10 clk = ~clk;

   iq_undersample_demod #(.WIN_LEN(L)) i_iq_undersample_demod (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
      .in_sample(in_sample), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int cw [5] = '{16384, 5063, -13255, -13255, 5063};
   int sw [5] = '{0, 15582, 9630, -9630, -15582};

   bit     m_run = 0;
   int     m_cnt = 0;
   int     m_ph = 0;
   longint m_ai = 0, m_aq = 0;
   bit     pend = 0;
   int     due = -1;
   logic signed [OW-1:0] exp_i, exp_q;
   logic signed [OW-1:0] hold_i = '0, hold_q = '0;
   logic [15:0] lfsr = 16'hACE1;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic signed [OW-1:0] scale(input longint acc);
      logic signed [127:0] a, rc, p;
      a  = 128'(acc);
      rc = 128'(((longint'(1) <<< (SH + 1)) + L / 2) / L);
      p  = (a * rc) >>> SH;
      return p[OW-1:0];
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cyc);
      end
   endtask

   // drive one cycle; update the reference model
   task automatic put(input int x, input bit st, input bit v);
      @(posedge clk); #1;
      in_valid  = v;
      in_start  = st;
      in_sample = SW'(x);
      if (v) begin
         if (st) begin
            m_run = 1; m_cnt = 0; m_ph = 0; m_ai = 0; m_aq = 0;
         end
         if (m_run) begin
            m_ai += longint'(x) * cw[m_ph];
            m_aq += longint'(x) * sw[m_ph];
            m_ph  = (m_ph + 4) % 5;
            m_cnt++;
            if (m_cnt == L) begin
               m_run = 0;
               pend  = 1;
               due   = cyc + 3;
               exp_i = scale(m_ai);
               exp_q = scale(m_aq);
            end
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) put(i * 37 - 500, i[0], 0);
   endtask

   // monitor, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (pend && cyc == due) begin
            chk(out_valid === 1'b1, "R6 strobe", out_valid, 1);
            chk(out_i === exp_i, "R4 I", out_i, exp_i);
            chk(out_q === exp_q, "R5 Q", out_q, exp_q);
            pend = 0;
            hold_i = out_i;
            hold_q = out_q;
         end else begin
            chk(out_valid === 1'b0, "R6/R9 unexpected strobe", out_valid, 0);
            chk(out_i === hold_i && out_q === hold_q, "R10 hold", out_i, hold_i);
         end
      end
   end

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int x;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1
      chk(out_valid === 1'b0, "R1 valid", out_valid, 0);
      chk(out_i === '0 && out_q === '0, "R1 data", out_i, 0);
      rst_n = 1'b1;

      // R9: samples before any start
      for (int i = 0; i < 12; i++) put(4000 - i * 300, 0, 1);
      idle(4);

      // R2 R3 R11: impulse at each position, both extremes, windows back to back
      for (int s = 0; s < 2; s++)
         for (int j = 0; j < L; j++)
            for (int k = 0; k < L; k++)
               put((k == j) ? ((s == 0) ? 8191 : -8192) : 0, k == 0, 1);
      idle(4);

      // R4 R5: synthetic tones built from the weight table
      for (int t = 0; t < 4; t++) begin
         for (int k = 0; k < L; k++) begin
            int p;
            p = (4 * k) % 5;
            x = (cw[p] * (2000 + 1500 * t) + sw[p] * (3000 - 2000 * t)) / 16384;
            put(x, k == 0, 1);
         end
         idle(2);
      end

      // R7: gaps with junk data and stray start
      for (int k = 0; k < L; k++) begin
         put(100 * k - 7000, k == 0, 1);
         put(-8192 + k, 1, 0);
         if (k % 3 == 0) put(8191, 1, 0);
      end
      idle(4);

      // R8: restart after four samples
      for (int k = 0; k < 4; k++) put(6000, k == 0, 1);
      for (int k = 0; k < L; k++) put(-1234 + 500 * k, k == 0, 1);
      idle(4);

      // R9: samples after completion are ignored
      for (int k = 0; k < L; k++) put(321 * k - 1600, k == 0, 1);
      for (int k = 0; k < 15; k++) put(8000, 0, 1);
      idle(4);

      // R4 R5 R11: pseudo-random windows, back to back
      for (int w = 0; w < 30; w++)
         for (int k = 0; k < L; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            put($signed(lfsr[13:0]), k == 0, 1);
         end
      idle(8);

      chk(pend == 0, "R6 outstanding result", pend, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule